// File: doc/BRIEF.md
# Mixed-length instruction aligner and decoder

This block sits between an instruction fetch unit and an issue stage. It takes a stream of 32-bit little-endian fetch words and cuts it into instructions that are 16 or 24 bits long. The two sizes follow each other with no padding, and any instruction may start in one fetch word and end in the next. The size of each instruction is read from the low nibble of its first byte, the opcode nibble `op0`.

For every instruction the block gives its byte address and its word, zero-extended to 24 bits. It also gives a size bit, the three 4-bit register selectors, and a flag that marks both encodings of the register-register add. Fetch words enter through a valid/ready handshake and instructions leave through another. A flush empties the byte buffer and restarts extraction at any byte address.

Top module: `mixlen_aligner`

## Requirements
- R1: During and directly after reset, out_valid_o is 0, fetch_ready_o is 1 and the first instruction is reported at address 0.
- R2: An instruction is 16 bits long when op0 (bits [3:0] of its first byte) lies in 8..13 and 24 bits long otherwise; out_len16_o is 1 for the 16-bit size.
- R3: Bytes are little-endian: the first stream byte is out_insn_o[7:0]. A 16-bit instruction reports out_insn_o[23:16] = 0.
- R4: Instructions are packed back to back with no padding, and one may straddle a fetch word boundary.
- R5: out_r_o = insn[15:12], out_s_o = insn[11:8] and out_t_o = insn[7:4], for both sizes.
- R6: out_is_add_o is 1 in two cases: a 24-bit word with insn[23:16] = 8'h80 and insn[3:0] = 4'h0, or a 16-bit word with insn[3:0] = 4'hA. It is 0 for every other word.
- R7: out_addr_o is the address of the instruction's first byte. It steps by 2 or 3 for each accepted instruction.
- R8: With flush_i low, fetch_ready_o is 1 exactly when the buffer holds at most BUF_BYTES-4 bytes. The buffer never exceeds BUF_BYTES.
- R9: With flush_i low, out_valid_o is 1 exactly when the buffer holds the whole next instruction. While out_ready_i is low the word and address do not change.
- R10: A flush empties the buffer and sets the next instruction address to flush_addr_i. The next accepted fetch word is the aligned word that holds that address, and its bytes below flush_addr_i[1:0] are dropped.
- R11: In a flush cycle fetch_ready_o and out_valid_o are 0. A fetch word or an output accept offered in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard buffer and restart |
| flush_addr_i | input | ADDR_W | Byte address to restart at |
| fetch_valid_i | input | 1 | Fetch word offered |
| fetch_ready_o | output | 1 | Fetch word can be taken |
| fetch_data_i | input | 32 | Fetch word, little-endian |
| out_valid_o | output | 1 | Instruction available |
| out_ready_i | input | 1 | Instruction taken |
| out_addr_o | output | ADDR_W | Instruction byte address |
| out_insn_o | output | 24 | Instruction word, zero-extended |
| out_len16_o | output | 1 | 1 for a 16-bit instruction |
| out_r_o | output | 4 | Destination selector |
| out_s_o | output | 4 | First source selector |
| out_t_o | output | 4 | Second source selector |
| out_is_add_o | output | 1 | Add encoding recognised |

## Verification
The buffer can accept a fetch word and release an instruction in the same cycle. When that happens the new bytes must land right after the bytes that remain. The bench provokes this by toggling fetch_valid_i and out_ready_i at random over mixed, all-16-bit, all-24-bit and corner-case streams, and it keeps its own byte count. Each field of every reported instruction is compared with a list built from the requirements. The bench also raises flush together with an offered fetch word and an output accept. It then checks that both handshakes are refused and that the following instructions come from the new address, with no stray bytes from the refused word.

// File: rtl/mixlen_pkg.sv
package mixlen_pkg;

  typedef struct packed {
    logic        len16;
    logic        is_add;
    logic [3:0]  r;
    logic [3:0]  s;
    logic [3:0]  t;
    logic [23:0] word;
  } insn_info_t;

  localparam logic [3:0] SHORT_OP_LO  = 4'd8;
  localparam logic [3:0] SHORT_OP_HI  = 4'd13;
  localparam logic [3:0] NARROW_ADD   = 4'hA;
  localparam logic [3:0] WIDE_ADD_LO  = 4'h0;
  localparam logic [7:0] WIDE_ADD_HI  = 8'h80;

  function automatic logic is_short(input logic [3:0] op0);
    return (op0 >= SHORT_OP_LO) && (op0 <= SHORT_OP_HI);
  endfunction

endpackage

// File: rtl/mixlen_bytebuf.sv
module mixlen_bytebuf #(
  parameter int BUF_BYTES = 6,
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int W = 8 * BUF_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [1:0]       flush_skip_i,
  input  logic             push_i,
  input  logic [31:0]      push_data_i,
  input  logic             pop_i,
  input  logic [1:0]       pop_len_i,
  output logic [23:0]      head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             room_o
);

  logic [W-1:0]     data_q, data_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic [1:0]       skip_q;
  logic [CNT_W-1:0] pop_n, keep, app_n;
  logic [W-1:0]     kept, placed;

  always_comb begin
    pop_n   = pop_i ? CNT_W'(pop_len_i) : '0;
    keep    = count_q - pop_n;
    app_n   = CNT_W'(4) - CNT_W'(skip_q);
    kept    = (data_q >> {pop_n, 3'b000}) & ~({W{1'b1}} << {keep, 3'b000});
    placed  = W'(push_data_i >> {skip_q, 3'b000}) << {keep, 3'b000};
    data_d  = push_i ? (kept | placed) : kept;
    count_d = keep + (push_i ? app_n : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      count_q <= '0;
      skip_q  <= '0;
    end else if (flush_i) begin
      count_q <= '0;
      skip_q  <= flush_skip_i;
    end else begin
      data_q  <= data_d;
      count_q <= count_d;
      if (push_i) skip_q <= '0;
    end
  end

  assign head_o  = data_q[23:0];
  assign count_o = count_q;
  assign room_o  = count_q <= CNT_W'(BUF_BYTES - 4);

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(BUF_BYTES));
  assert_push_fits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q + CNT_W'(4) <= CNT_W'(BUF_BYTES)));
  assert_pop_whole_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count_q >= CNT_W'(pop_len_i)));
  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));

endmodule

// File: rtl/mixlen_decode.sv
module mixlen_decode
  import mixlen_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic [23:0]      head_i,
  input  logic [CNT_W-1:0] count_i,
  output insn_info_t       info_o,
  output logic             whole_o
);

  logic short_w;

  always_comb begin
    short_w       = is_short(head_i[3:0]);
    info_o.len16  = short_w;
    info_o.word   = short_w ? {8'h00, head_i[15:0]} : head_i;
    info_o.r      = head_i[15:12];
    info_o.s      = head_i[11:8];
    info_o.t      = head_i[7:4];
    info_o.is_add = short_w ? (head_i[3:0] == NARROW_ADD)
                            : ((head_i[23:16] == WIDE_ADD_HI) && (head_i[3:0] == WIDE_ADD_LO));
    whole_o       = (count_i >= CNT_W'(3)) || (short_w && (count_i >= CNT_W'(2)));
  end

endmodule

// File: rtl/mixlen_aligner.sv
module mixlen_aligner
  import mixlen_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic              fetch_valid_i,
  output logic              fetch_ready_o,
  input  logic [31:0]       fetch_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [23:0]       out_insn_o,
  output logic              out_len16_o,
  output logic [3:0]        out_r_o,
  output logic [3:0]        out_s_o,
  output logic [3:0]        out_t_o,
  output logic              out_is_add_o
);

  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic [ADDR_W-1:0] pc_q;
  logic [23:0]       head;
  logic [CNT_W-1:0]  count;
  logic              room, whole, push, pop;
  logic [1:0]        pop_len;
  insn_info_t        info;

  assign fetch_ready_o = room && !flush_i;
  assign out_valid_o   = whole && !flush_i;
  assign push          = fetch_valid_i && fetch_ready_o;
  assign pop           = out_valid_o && out_ready_i;
  assign pop_len       = info.len16 ? 2'd2 : 2'd3;

  mixlen_bytebuf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .flush_skip_i (flush_addr_i[1:0]),
    .push_i       (push),
    .push_data_i  (fetch_data_i),
    .pop_i        (pop),
    .pop_len_i    (pop_len),
    .head_o       (head),
    .count_o      (count),
    .room_o       (room)
  );

  mixlen_decode #(.CNT_W(CNT_W)) u_dec (
    .head_i  (head),
    .count_i (count),
    .info_o  (info),
    .whole_o (whole)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (flush_i) pc_q <= flush_addr_i;
    else if (pop)     pc_q <= pc_q + ADDR_W'(pop_len);
  end

  assign out_addr_o   = pc_q;
  assign out_insn_o   = info.word;
  assign out_len16_o  = info.len16;
  assign out_r_o      = info.r;
  assign out_s_o      = info.s;
  assign out_t_o      = info.t;
  assign out_is_add_o = info.is_add;

  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=>
      out_addr_o == $past(out_addr_o) + ($past(out_len16_o) ? ADDR_W'(2) : ADDR_W'(3)));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> ($stable(out_insn_o) && $stable(out_addr_o)));
  assert_flush_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (out_addr_o == $past(flush_addr_i)));

endmodule

// File: tb/mixlen_aligner_tb.sv
module mixlen_aligner_tb;
  localparam int ADDR_W    = 32;
  localparam int BUF_BYTES = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              flush_i = 1'b0;
  logic [ADDR_W-1:0] flush_addr_i = '0;
  logic              fetch_valid_i = 1'b0;
  logic              fetch_ready_o;
  logic [31:0]       fetch_data_i = '0;
  logic              out_valid_o;
  logic              out_ready_i = 1'b0;
  logic [ADDR_W-1:0] out_addr_o;
  logic [23:0]       out_insn_o;
  logic              out_len16_o;
  logic [3:0]        out_r_o, out_s_o, out_t_o;
  logic              out_is_add_o;

  always #10 clk = ~clk;

  mixlen_aligner #(.ADDR_W(ADDR_W), .BUF_BYTES(BUF_BYTES)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .fetch_valid_i(fetch_valid_i), .fetch_ready_o(fetch_ready_o), .fetch_data_i(fetch_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_addr_o(out_addr_o),
    .out_insn_o(out_insn_o), .out_len16_o(out_len16_o), .out_r_o(out_r_o),
    .out_s_o(out_s_o), .out_t_o(out_t_o), .out_is_add_o(out_is_add_o)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0]  seg_b [0:255];
  logic [23:0] e_word [0:63];
  logic        e_len16 [0:63];
  logic [31:0] e_addr [0:63];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_short(input logic [3:0] op0);
    return (op0 >= 4'd8) && (op0 <= 4'd13);
  endfunction

  function automatic logic exp_add(input logic [23:0] w, input logic sh);
    if (sh) return w[3:0] == 4'hA;
    return (w[23:16] == 8'h80) && (w[3:0] == 4'h0);
  endfunction

  function automatic logic [24:0] gen(input int mode, input int idx);
    logic [23:0] w;
    logic        sh;
    int          v;
    if (mode == 3) begin
      case (idx % 8)
        0: w = 24'h805630;
        1: w = 24'h009C4A;
        2: w = 24'h812340;
        3: w = 24'h123457;
        4: w = 24'h00ABC8;
        5: w = 24'h00123D;
        6: w = 24'h0FFFFE;
        default: w = 24'h00000A;
      endcase
      return {exp_short(w[3:0]), w};
    end
    sh = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom % 2);
    w  = 24'($urandom);
    if (sh) begin
      w[23:16] = 8'h00;
      w[3:0]   = 4'(8 + $urandom % 6);
      if ($urandom % 4 == 0) w[3:0] = 4'hA;
    end else begin
      v = $urandom % 10;
      w[3:0] = 4'((v < 8) ? v : v + 6);
      if ($urandom % 4 == 0) begin
        w[23:16] = 8'h80;
        w[3:0]   = 4'h0;
      end
    end
    return {sh, w};
  endfunction

  task automatic run(input logic [31:0] start, input int n, input int mode,
                     input bit do_flush, input int rdy_pct);
    int pos, nwords, wi, done, cnt, need;
    logic [31:0] a;
    logic [24:0] g;
    bit fv, push, pop, expv;
    pos = 0;
    for (int k = 0; k < int'(start[1:0]); k++) begin seg_b[pos] = 8'($urandom); pos++; end
    a = start;
    for (int i = 0; i < n; i++) begin
      g = gen(mode, i);
      e_len16[i] = g[24];
      e_word[i]  = g[23:0];
      e_addr[i]  = a;
      seg_b[pos] = g[7:0]; seg_b[pos+1] = g[15:8]; pos += 2;
      if (!g[24]) begin seg_b[pos] = g[23:16]; pos++; end
      a += g[24] ? 32'd2 : 32'd3;
    end
    while (pos % 4 != 0) begin seg_b[pos] = 8'($urandom); pos++; end
    nwords = pos / 4;

    if (do_flush) begin
      // R11: flush together with offered fetch word and output accept
      @(negedge clk);
      flush_i = 1'b1; flush_addr_i = start;
      fetch_valid_i = 1'b1; fetch_data_i = $urandom; out_ready_i = 1'b1;
      #1;
      chk("R11 fetch_ready_o in flush", 32'(fetch_ready_o), 32'd0);
      chk("R11 out_valid_o in flush", 32'(out_valid_o), 32'd0);
    end

    wi = 0; done = 0; cnt = 0;
    while (done < n) begin
      @(negedge clk);
      flush_i = 1'b0;
      fv = (wi < nwords) && ($urandom % 100 < 70);
      fetch_valid_i = fv;
      fetch_data_i  = fv ? {seg_b[4*wi+3], seg_b[4*wi+2], seg_b[4*wi+1], seg_b[4*wi]} : $urandom;
      out_ready_i   = ($urandom % 100) < rdy_pct;
      #1;
      need = e_len16[done] ? 2 : 3;
      expv = cnt >= need;
      chk("R8 fetch_ready_o", 32'(fetch_ready_o), 32'(cnt <= BUF_BYTES - 4));
      chk("R9 out_valid_o", 32'(out_valid_o), 32'(expv));
      if (out_valid_o) begin
        chk("R7 R10 out_addr_o", out_addr_o, e_addr[done]);
        chk("R2 out_len16_o", 32'(out_len16_o), 32'(e_len16[done]));
        chk("R3 R4 out_insn_o", 32'(out_insn_o), 32'(e_word[done]));
        chk("R5 out_r_o", 32'(out_r_o), 32'(e_word[done][15:12]));
        chk("R5 out_s_o", 32'(out_s_o), 32'(e_word[done][11:8]));
        chk("R5 out_t_o", 32'(out_t_o), 32'(e_word[done][7:4]));
        chk("R6 out_is_add_o", 32'(out_is_add_o), 32'(exp_add(e_word[done], e_len16[done])));
      end
      push = fv && fetch_ready_o;
      pop  = out_valid_o && out_ready_i;
      @(posedge clk);
      if (push) begin
        cnt += (wi == 0) ? 4 - int'(start[1:0]) : 4;
        wi++;
      end
      if (pop) begin
        cnt -= need;
        done++;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #5;
    chk("R1 out_valid_o in reset", 32'(out_valid_o), 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 fetch_ready_o after reset", 32'(fetch_ready_o), 32'd1);
    chk("R1 out_valid_o after reset", 32'(out_valid_o), 32'd0);
    chk("R1 out_addr_o after reset", out_addr_o, 32'd0);

    run(32'h0000_0000, 20, 0, 1'b0, 100);
    run(32'h0000_0102, 20, 1, 1'b1, 60);
    run(32'h0000_0203, 20, 2, 1'b1, 50);
    run(32'h0000_0301, 16, 3, 1'b1, 100);
    run(32'h0000_0400, 16, 3, 1'b1, 30);
    for (int k = 0; k < 12; k++) begin
      run($urandom & 32'h00FF_FFFF, 30, 0, 1'b1, (k % 3 == 0) ? 100 : (k % 3 == 1) ? 70 : 40);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired, run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule